// File: doc/BRIEF.md
# Temperature Sensor Scratchpad Register File

This block is the device-side storage of a single-wire temperature sensor. It holds a nine-byte scratchpad and a shadow copy of its user-writable part. An upstream decoder presents one function command byte at a time on `cmd_valid`/`cmd_byte`. Data then moves one bit per time slot over two valid/ready streams. The write stream carries master-to-device bits and the read stream carries device-to-master bits. Back-pressure works the same way on both streams: a bit moves only in a cycle where valid and ready are both high. The read stream holds its bit unchanged for as long as the consumer keeps `rbit_ready` low. A command strobe always wins over stream traffic in the same cycle: while `cmd_valid` is high, `wbit_ready` and `rbit_valid` are forced low.

The layout of the scratchpad is fixed:

| Byte | Content |
|------|---------|
| 0 | Temperature, low byte |
| 1 | Temperature, high byte |
| 2 | Upper alarm threshold |
| 3 | Lower alarm threshold |
| 4 | Configuration |
| 5, 6, 7 | Constants FFh, 0Ch, 10h |
| 8 | Check byte |

The conversion logic loads the temperature through a parallel port. The bus can never write bytes 0 and 1.

Two resets are provided. `por_n` returns the shadow set to its build-time defaults. `rst_n` returns the command logic to idle and reloads bytes 2 to 4 from the shadow set.

Top module: `thermo_scratchpad`

## Requirements
- R1: After `rst_n` is released, the block is idle: `wbit_ready` and `rbit_valid` are both low. After power-on reset, the shadow outputs read `nv_th`=4Bh, `nv_tl`=46h and `nv_cfg`=7Fh, and the temperature bytes read 50h and 05h.
- R2: Command BEh streams 72 bits. The order is byte 0 through byte 8, and each byte goes least significant bit first. All 72 bits come from a snapshot taken in the cycle the command is accepted. After the last bit the block is idle.
- R3: Bytes 5, 6 and 7 always read FFh, 0Ch and 10h. No command changes them.
- R4: The configuration byte reads as {0, R1, R0, 11111b}, where R1 is bit 6 and R0 is bit 5. A write changes only bits 6 and 5.
- R5: Command 4Eh accepts exactly 24 bits, least significant bit of byte 2 first, then byte 3, then byte 4. Bytes 2 to 4 change together in the cycle the 24th bit is accepted.
- R6: Byte 8 is a CRC over bytes 0 to 7. It uses polynomial x^8+x^5+x^4+1, starts from 00h and takes each byte least significant bit first. For the power-on content the CRC is 1Ch.
- R7: Command 48h copies bytes 2, 3 and 4 into `nv_th`, `nv_tl` and `nv_cfg` at the next clock edge. No other command changes the shadow outputs.
- R8: A `temp_load` pulse sets bytes 0 and 1 to `temp_value` at the next edge. The bus has no path that writes them.
- R9: A command strobe that arrives during a read or a write ends the transfer at once. The new command then takes effect. A partly received write is discarded and leaves bytes 2 to 4 unchanged.
- R10: A stream bit moves only when valid and ready are high together. While `rbit_ready` is low, `rbit_data` holds its value.
- R11: `rst_n` alone reloads bytes 2 to 4 from the current shadow values. `por_n` restores the shadow defaults.
- R12: A command byte other than 4Eh, BEh or 48h leaves the block idle and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset: command logic idle, writable bytes reloaded from shadow |
| por_n | input | 1 | Synchronous power-on reset of the shadow set |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_byte | input | 8 | Decoded function command |
| wbit_valid | input | 1 | Write stream: a bit is offered |
| wbit_ready | output | 1 | Write stream: the block takes a bit |
| wbit_data | input | 1 | Write stream bit |
| rbit_valid | output | 1 | Read stream: a bit is offered |
| rbit_ready | input | 1 | Read stream: the consumer takes the bit |
| rbit_data | output | 1 | Read stream bit |
| temp_load | input | 1 | Load strobe for the temperature bytes |
| temp_value | input | 16 | New temperature, two's complement |
| nv_th | output | 8 | Shadow upper alarm threshold |
| nv_tl | output | 8 | Shadow lower alarm threshold |
| nv_cfg | output | 8 | Shadow configuration byte |

## Verification
The hardest situations to reach from the ports involve a transfer that is interrupted or overlapped by another event. One case is a command strobe that cuts off a write after some of its bits. Another is a temperature load that lands in the middle of a read. In both, the visible effect depends on which cycle the interruption hits. The stimulus reaches these cases by splitting a transfer into two bursts of chosen bit counts. Between the bursts it injects the second command or the load pulse. It then runs a full fresh read, so any corruption of the writable bytes or of the snapshot shows up in the streamed bits. Stalls in both streams are driven with regular gaps, so a bit is held across several cycles.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } tsp_state_e;

  localparam logic [7:0] CMD_WRITE = 8'h4E;
  localparam logic [7:0] CMD_READ  = 8'hBE;
  localparam logic [7:0] CMD_COPY  = 8'h48;

  localparam logic [7:0] RSV_B5 = 8'hFF;
  localparam logic [7:0] RSV_B6 = 8'h0C;
  localparam logic [7:0] RSV_B7 = 8'h10;

  // writable configuration bits and fixed ones
  localparam logic [7:0] CFG_WR_MASK = 8'h60;
  localparam logic [7:0] CFG_FIXED   = 8'h1F;

  // x^8+x^5+x^4+1, bit-reversed for LSB-first shifting
  localparam logic [7:0] CRC_POLY_REFL = 8'h8C;

  function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in,
                                           input logic [7:0] data);
    logic [7:0] c;
    logic       fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ data[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

endpackage

// File: rtl/tsp_crc8.sv
module tsp_crc8
  import tsp_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  logic [NBYTES*8-1:0] data_i,
  output logic [7:0]          crc_o
);

  logic [NBYTES:0][7:0] stage;

  assign stage[0] = 8'h00;

  generate
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      assign stage[g+1] = crc8_byte(stage[g], data_i[g*8 +: 8]);
    end
  endgenerate

  assign crc_o = stage[NBYTES];

endmodule

// File: rtl/tsp_regs.sv
module tsp_regs
  import tsp_pkg::*;
#(
  parameter logic [15:0] TEMP_INIT = 16'h0550,
  parameter logic [7:0]  TH_INIT   = 8'h4B,
  parameter logic [7:0]  TL_INIT   = 8'h46,
  parameter logic [1:0]  RES_INIT  = 2'b11,
  localparam int         WR_BITS   = 24,
  localparam int         IMG_BITS  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                por_n,
  input  logic                temp_load,
  input  logic [15:0]         temp_value,
  input  logic                commit,
  input  logic [WR_BITS-1:0]  commit_data,
  input  logic                copy,
  output logic [15:0]         temp_q,
  output logic [7:0]          th_q,
  output logic [7:0]          tl_q,
  output logic [7:0]          cfg_q,
  output logic [7:0]          nv_th,
  output logic [7:0]          nv_tl,
  output logic [7:0]          nv_cfg,
  output logic [IMG_BITS-1:0] image_o
);

  localparam logic [7:0] CFG_INIT = {1'b0, RES_INIT, 5'h1F};

  // shadow (non-volatile) set
  always_ff @(posedge clk) begin
    if (!por_n) begin
      nv_th  <= TH_INIT;
      nv_tl  <= TL_INIT;
      nv_cfg <= CFG_INIT;
    end else if (copy) begin
      nv_th  <= th_q;
      nv_tl  <= tl_q;
      nv_cfg <= cfg_q;
    end
  end

  // writable scratchpad bytes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      th_q  <= nv_th;
      tl_q  <= nv_tl;
      cfg_q <= nv_cfg;
    end else if (commit) begin
      th_q  <= commit_data[7:0];
      tl_q  <= commit_data[15:8];
      cfg_q <= (commit_data[23:16] & CFG_WR_MASK) | CFG_FIXED;
    end
  end

  // temperature bytes
  always_ff @(posedge clk) begin
    if (!rst_n)         temp_q <= TEMP_INIT;
    else if (temp_load) temp_q <= temp_value;
  end

  assign image_o = {RSV_B7, RSV_B6, RSV_B5, cfg_q, tl_q, th_q,
                    temp_q[15:8], temp_q[7:0]};

endmodule

// File: rtl/tsp_seq.sv
module tsp_seq
  import tsp_pkg::*;
#(
  parameter  int WR_BITS = 24,
  parameter  int RD_BITS = 72,
  localparam int CW      = $clog2(RD_BITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_byte,
  input  logic               wbit_valid,
  output logic               wbit_ready,
  input  logic               wbit_data,
  output logic               rbit_valid,
  input  logic               rbit_ready,
  output logic               rbit_data,
  input  logic [RD_BITS-1:0] read_image,
  output logic               commit,
  output logic [WR_BITS-1:0] commit_data,
  output logic               copy
);

  tsp_state_e         state_q;
  logic [CW-1:0]      cnt_q;
  logic [WR_BITS-1:0] wr_sr;
  logic [RD_BITS-1:0] rd_sr;
  logic               wbeat, rbeat, wr_last, rd_last;

  assign wbit_ready = (state_q == ST_WRITE) && !cmd_valid;
  assign rbit_valid = (state_q == ST_READ) && !cmd_valid;
  assign rbit_data  = rd_sr[0];

  assign wbeat   = wbit_valid && wbit_ready;
  assign rbeat   = rbit_valid && rbit_ready;
  assign wr_last = wbeat && (cnt_q == CW'(WR_BITS - 1));
  assign rd_last = rbeat && (cnt_q == CW'(RD_BITS - 1));

  assign commit      = wr_last;
  assign commit_data = {wbit_data, wr_sr[WR_BITS-1:1]};
  assign copy        = rst_n && cmd_valid && (cmd_byte == CMD_COPY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (cmd_valid) begin
      cnt_q <= '0;
      case (cmd_byte)
        CMD_WRITE: state_q <= ST_WRITE;
        CMD_READ:  state_q <= ST_READ;
        default:   state_q <= ST_IDLE;
      endcase
    end else if (wbeat) begin
      if (wr_last) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (rbeat) begin
      if (rd_last) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // LSB-first assembly of incoming bits
  always_ff @(posedge clk) begin
    if (wbeat) wr_sr <= {wbit_data, wr_sr[WR_BITS-1:1]};
  end

  // snapshot at command time, then shift out LSB first
  always_ff @(posedge clk) begin
    if (cmd_valid && (cmd_byte == CMD_READ)) rd_sr <= read_image;
    else if (rbeat)                          rd_sr <= {1'b0, rd_sr[RD_BITS-1:1]};
  end

endmodule

// File: rtl/thermo_scratchpad.sv
module thermo_scratchpad
  import tsp_pkg::*;
#(
  parameter  logic [15:0] TEMP_INIT = 16'h0550,
  parameter  logic [7:0]  TH_INIT   = 8'h4B,
  parameter  logic [7:0]  TL_INIT   = 8'h46,
  parameter  logic [1:0]  RES_INIT  = 2'b11,
  localparam int          NBYTES    = 9,
  localparam int          IMG_BITS  = (NBYTES - 1) * 8,
  localparam int          RD_BITS   = NBYTES * 8,
  localparam int          WR_BITS   = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_byte,
  input  logic        wbit_valid,
  output logic        wbit_ready,
  input  logic        wbit_data,
  output logic        rbit_valid,
  input  logic        rbit_ready,
  output logic        rbit_data,
  input  logic        temp_load,
  input  logic [15:0] temp_value,
  output logic [7:0]  nv_th,
  output logic [7:0]  nv_tl,
  output logic [7:0]  nv_cfg
);

  logic [15:0]         temp_q;
  logic [7:0]          th_q, tl_q, cfg_q;
  logic [IMG_BITS-1:0] image;
  logic [7:0]          crc;
  logic                commit, copy;
  logic [WR_BITS-1:0]  commit_data;

  tsp_regs #(
    .TEMP_INIT(TEMP_INIT),
    .TH_INIT  (TH_INIT),
    .TL_INIT  (TL_INIT),
    .RES_INIT (RES_INIT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_n      (por_n),
    .temp_load  (temp_load),
    .temp_value (temp_value),
    .commit     (commit),
    .commit_data(commit_data),
    .copy       (copy),
    .temp_q     (temp_q),
    .th_q       (th_q),
    .tl_q       (tl_q),
    .cfg_q      (cfg_q),
    .nv_th      (nv_th),
    .nv_tl      (nv_tl),
    .nv_cfg     (nv_cfg),
    .image_o    (image)
  );

  tsp_crc8 #(.NBYTES(NBYTES - 1)) u_crc (
    .data_i(image),
    .crc_o (crc)
  );

  tsp_seq #(
    .WR_BITS(WR_BITS),
    .RD_BITS(RD_BITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .wbit_valid (wbit_valid),
    .wbit_ready (wbit_ready),
    .wbit_data  (wbit_data),
    .rbit_valid (rbit_valid),
    .rbit_ready (rbit_ready),
    .rbit_data  (rbit_data),
    .read_image ({crc, image}),
    .commit     (commit),
    .commit_data(commit_data),
    .copy       (copy)
  );

endmodule

// File: rtl/tsp_chk.sv
module tsp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [7:0]  cmd_byte,
  input logic        wbit_valid,
  input logic        wbit_ready,
  input logic        rbit_valid,
  input logic        rbit_ready,
  input logic        rbit_data,
  input logic        temp_load,
  input logic [15:0] temp_value,
  input logic [15:0] temp_q,
  input logic [7:0]  th_q,
  input logic [7:0]  tl_q,
  input logic [7:0]  cfg_q,
  input logic [7:0]  nv_th,
  input logic [7:0]  nv_tl,
  input logic [7:0]  nv_cfg
);

  // R10
  stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wbit_ready && rbit_valid));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rbit_valid && !rbit_ready) |=> (!rbit_valid || $stable(rbit_data)));

  // R7
  copy_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'h48) |=>
      (nv_th == $past(th_q) && nv_tl == $past(tl_q) && nv_cfg == $past(cfg_q)));

  // R9
  wr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || !(wbit_valid && wbit_ready)) |=>
      ($stable(th_q) && $stable(tl_q) && $stable(cfg_q)));

  // R8
  temp_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    temp_load |=> (temp_q == $past(temp_value)));

  // R12
  shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_byte == 8'h48) |=>
      ($stable(nv_th) && $stable(nv_tl) && $stable(nv_cfg)));

endmodule

bind thermo_scratchpad tsp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_byte  (cmd_byte),
  .wbit_valid(wbit_valid),
  .wbit_ready(wbit_ready),
  .rbit_valid(rbit_valid),
  .rbit_ready(rbit_ready),
  .rbit_data (rbit_data),
  .temp_load (temp_load),
  .temp_value(temp_value),
  .temp_q    (temp_q),
  .th_q      (th_q),
  .tl_q      (tl_q),
  .cfg_q     (cfg_q),
  .nv_th     (nv_th),
  .nv_tl     (nv_tl),
  .nv_cfg    (nv_cfg)
);

// File: tb/thermo_scratchpad_tb.sv
`timescale 1ns/1ps
module thermo_scratchpad_tb;

  logic        clk = 1'b0;
  logic        rst_n, por_n;
  logic        cmd_valid;
  logic [7:0]  cmd_byte;
  logic        wbit_valid, wbit_data, rbit_ready;
  logic        wbit_ready, rbit_valid, rbit_data;
  logic        temp_load;
  logic [15:0] temp_value;
  logic [7:0]  nv_th, nv_tl, nv_cfg;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  thermo_scratchpad u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .wbit_valid(wbit_valid), .wbit_ready(wbit_ready), .wbit_data(wbit_data),
    .rbit_valid(rbit_valid), .rbit_ready(rbit_ready), .rbit_data(rbit_data),
    .temp_load(temp_load), .temp_value(temp_value),
    .nv_th(nv_th), .nv_tl(nv_tl), .nv_cfg(nv_cfg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [15:0] m_temp;
  logic [7:0]  m_th, m_tl, m_cfg, s_th, s_tl, s_cfg;
  int          m_state = 0;   // 0 idle, 1 write, 2 read
  bit          wq[$];
  bit          rq[$];

  function automatic logic [7:0] ref_crc(input logic [63:0] bytes);
    logic [7:0] r = 8'h00;
    for (int k = 0; k < 64; k++) begin
      logic mix = r[0] ^ bytes[k];
      r = {mix, r[7:1]};
      r[3] = r[3] ^ mix;   // x^4 term
      r[2] = r[2] ^ mix;   // x^5 term
    end
    return r;
  endfunction

  function automatic logic [63:0] m_image();
    return {8'h10, 8'h0C, 8'hFF, m_cfg, m_tl, m_th, m_temp};
  endfunction

  always @(posedge clk) begin
    logic [63:0] img;
    if (!rst_n) begin
      m_state = 0; m_temp = 16'h0550;
      m_th = s_th; m_tl = s_tl; m_cfg = s_cfg;
      wq.delete(); rq.delete();
    end else begin
      if (cmd_valid) begin
        wq.delete(); rq.delete();
        case (cmd_byte)
          8'h4E: m_state = 1;
          8'hBE: begin
            m_state = 2;
            img = m_image();
            for (int k = 0; k < 64; k++) rq.push_back(img[k]);
            img[7:0] = ref_crc(m_image());
            for (int k = 0; k < 8; k++) rq.push_back(img[k]);
          end
          8'h48: begin m_state = 0; s_th = m_th; s_tl = m_tl; s_cfg = m_cfg; end
          default: m_state = 0;
        endcase
      end else if (m_state == 1 && wbit_valid) begin
        wq.push_back(wbit_data);
        if (wq.size() == 24) begin
          for (int k = 0; k < 8; k++) begin m_th[k] = wq[k]; m_tl[k] = wq[8+k]; end
          m_cfg = {1'b0, wq[22], wq[21], 5'h1F};
          wq.delete(); m_state = 0;
        end
      end else if (m_state == 2 && rbit_ready) begin
        void'(rq.pop_front());
        if (rq.size() == 0) m_state = 0;
      end
      if (temp_load) m_temp = temp_value;
    end
    if (!por_n) begin s_th = 8'h4B; s_tl = 8'h46; s_cfg = 8'h7F; end
    #1;
    if (rst_n && por_n) begin
      chk(wbit_ready === ((m_state == 1) && !cmd_valid), "R5/R10 wbit_ready",
          32'(wbit_ready), 32'((m_state == 1) && !cmd_valid));
      chk(rbit_valid === ((m_state == 2) && !cmd_valid), "R2/R10 rbit_valid",
          32'(rbit_valid), 32'((m_state == 2) && !cmd_valid));
      if (rbit_valid && rq.size() > 0)
        chk(rbit_data === rq[0], "R2/R10 rbit_data", 32'(rbit_data), 32'(rq[0]));
      chk({nv_th, nv_tl, nv_cfg} === {s_th, s_tl, s_cfg}, "R7/R11 shadow",
          {8'h0, nv_th, nv_tl, nv_cfg}, {8'h0, s_th, s_tl, s_cfg});
    end
  end

  // ---------------- stimulus helpers ----------------
  bit rx[$];

  function automatic logic [7:0] rx_byte(input int b);
    logic [7:0] v;
    for (int j = 0; j < 8; j++) v[j] = rx[b*8 + j];
    return v;
  endfunction

  task automatic do_reset(input bit with_por);
    @(negedge clk);
    rst_n = 1'b0;
    if (with_por) por_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic write_bits(input logic [23:0] d, input int n, input bit stall);
    for (int i = 0; i < n; i++) begin
      bit took = 0;
      if (stall && (i % 3 == 0)) begin
        @(negedge clk); wbit_valid = 1'b0;
      end
      while (!took) begin
        @(negedge clk);
        wbit_valid = 1'b1; wbit_data = d[i];
        #1 took = wbit_ready;
      end
    end
    @(negedge clk);
    wbit_valid = 1'b0;
  endtask

  task automatic read_bits(input int n, input bit stall);
    int got = 0;
    int cyc = 0;
    while (got < n) begin
      @(negedge clk);
      rbit_ready = stall ? cyc[0] : 1'b1;
      cyc++;
      #1;
      if (rbit_valid && rbit_ready) begin rx.push_back(rbit_data); got++; end
    end
    @(negedge clk);
    rbit_ready = 1'b0;
  endtask

  task automatic pulse_temp(input logic [15:0] v);
    @(negedge clk);
    temp_load = 1'b1; temp_value = v;
    @(negedge clk);
    temp_load = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] exp_b [9];
    rst_n = 0; por_n = 0; cmd_valid = 0; cmd_byte = 0;
    wbit_valid = 0; wbit_data = 0; rbit_ready = 0;
    temp_load = 0; temp_value = 0;
    repeat (4) @(negedge clk);
    rst_n = 1; por_n = 1;

    // R1 reset state
    @(negedge clk); #1;
    chk(!wbit_ready && !rbit_valid, "R1 idle", {wbit_ready, rbit_valid}, 0);
    chk(nv_th == 8'h4B, "R1 nv_th", nv_th, 8'h4B);
    chk(nv_tl == 8'h46, "R1 nv_tl", nv_tl, 8'h46);
    chk(nv_cfg == 8'h7F, "R1 nv_cfg", nv_cfg, 8'h7F);

    // R2 R3 R4 R6 full power-on read
    rx.delete();
    send_cmd(8'hBE);
    read_bits(72, 0);
    exp_b = '{8'h50, 8'h05, 8'h4B, 8'h46, 8'h7F, 8'hFF, 8'h0C, 8'h10, 8'h1C};
    for (int b = 0; b < 9; b++)
      chk(rx_byte(b) == exp_b[b], "R2/R3/R4/R6 power-on byte", rx_byte(b), exp_b[b]);
    #1 chk(!rbit_valid, "R2 idle after 72 bits", rbit_valid, 0);

    // R5 R4 write with stalls; cfg 9Fh keeps only bits 6,5 -> 1Fh
    send_cmd(8'h4E);
    write_bits(24'h9F3CA5, 24, 1);
    #1 chk(!wbit_ready, "R5 idle after 24 bits", wbit_ready, 0);
    rx.delete();
    send_cmd(8'hBE);
    read_bits(72, 1);
    chk(rx_byte(2) == 8'hA5, "R5 byte2", rx_byte(2), 8'hA5);
    chk(rx_byte(3) == 8'h3C, "R5 byte3", rx_byte(3), 8'h3C);
    chk(rx_byte(4) == 8'h1F, "R4 cfg mask", rx_byte(4), 8'h1F);
    chk(rx_byte(8) == ref_crc({8'h10, 8'h0C, 8'hFF, 8'h1F, 8'h3C, 8'hA5, 16'h0550}),
        "R6 crc", rx_byte(8), ref_crc({8'h10, 8'h0C, 8'hFF, 8'h1F, 8'h3C, 8'hA5, 16'h0550}));
    chk(nv_th == 8'h4B, "R7 no copy yet", nv_th, 8'h4B);

    // R7 copy
    send_cmd(8'h48);
    #1;
    chk({nv_th, nv_tl, nv_cfg} == 24'hA53C1F, "R7 copy", {nv_th, nv_tl, nv_cfg}, 24'hA53C1F);

    // R8 temperature load
    pulse_temp(16'hFC90);
    rx.delete();
    send_cmd(8'hBE);
    read_bits(72, 0);
    chk({rx_byte(1), rx_byte(0)} == 16'hFC90, "R8 temp bytes", {rx_byte(1), rx_byte(0)}, 16'hFC90);

    // R2 snapshot: load lands mid-read
    rx.delete();
    send_cmd(8'hBE);
    read_bits(8, 0);
    pulse_temp(16'h0191);
    read_bits(64, 1);
    chk({rx_byte(1), rx_byte(0)} == 16'hFC90, "R2 snapshot", {rx_byte(1), rx_byte(0)}, 16'hFC90);
    rx.delete();
    send_cmd(8'hBE);
    read_bits(72, 0);
    chk({rx_byte(1), rx_byte(0)} == 16'h0191, "R8 new temp", {rx_byte(1), rx_byte(0)}, 16'h0191);

    // R9 aborted write
    send_cmd(8'h4E);
    write_bits(24'h112233, 10, 0);
    rx.delete();
    send_cmd(8'hBE);
    read_bits(72, 0);
    chk(rx_byte(2) == 8'hA5 && rx_byte(3) == 8'h3C, "R9 partial write dropped",
        {rx_byte(3), rx_byte(2)}, 16'h3CA5);

    // R9 R12 aborted read by unknown command
    send_cmd(8'hBE);
    read_bits(20, 0);
    send_cmd(8'h33);
    #1 chk(!rbit_valid && !wbit_ready, "R9/R12 idle after abort", {rbit_valid, wbit_ready}, 0);
    chk(nv_th == 8'hA5, "R12 shadow kept", nv_th, 8'hA5);

    // R11 rst_n alone reloads from shadow
    send_cmd(8'h4E);
    write_bits(24'h7F0102, 24, 0);
    do_reset(0);
    rx.delete();
    send_cmd(8'hBE);
    read_bits(72, 0);
    chk({rx_byte(4), rx_byte(3), rx_byte(2)} == 24'h1F3CA5, "R11 reload shadow",
        {rx_byte(4), rx_byte(3), rx_byte(2)}, 24'h1F3CA5);
    chk({rx_byte(1), rx_byte(0)} == 16'h0550, "R1 temp after reset",
        {rx_byte(1), rx_byte(0)}, 16'h0550);

    // R11 power-on reset restores defaults
    do_reset(1);
    @(negedge clk); #1;
    chk({nv_th, nv_tl, nv_cfg} == 24'h4B467F, "R11 por defaults",
        {nv_th, nv_tl, nv_cfg}, 24'h4B467F);

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule